// File: doc/BRIEF.md
# Receive Descriptor Ring Doorbell Poller

This block controls the receive side of a network MAC's descriptor ring. Software fills a small local ring of receive descriptors, marks each usable buffer as empty, and then rings a doorbell by writing any value to a 32-bit register. Writing the doorbell arms an active flag. While the flag is armed and the MAC enable is high, the block walks the ring. It offers each empty buffer to a frame source. When the frame completes, the block writes back the received length, clears the empty mark and moves to the next slot.

Walking stops at the first slot found not empty. At that point the block drops the active flag by itself, and software must ring the doorbell again after it has refilled the ring. Dropping the MAC enable clears the flag and returns the ring index to slot 0. A frame that starts while no buffer is on offer is counted in a saturating drop counter. The index returns to slot 0 after a slot whose wrap mark is set. It also returns to slot 0 after the last physical slot.

Top module: `rx_ring_poller`

## Requirements
- R1: When `mac_en` is high, a cycle with `reg_wr` high sets the active flag, whatever value is on `reg_wdata`. The flag is visible on `reg_rdata` on the cycle after the write.
- R2: `reg_rdata` shows the active flag at bit 24. Every other bit of `reg_rdata` always reads 0.
- R3: The block neither fetches a slot nor raises `buf_valid` while the active flag is clear or `mac_en` is low.
- R4: When a fetched slot has its empty mark clear, the active flag is cleared. No buffer is offered until the doorbell is written again.
- R5: The active flag is 0 after reset. It is held at 0 while `mac_en` is low, so doorbell writes made while `mac_en` is low leave no effect.
- R6: A slot is 50 bits wide: bit 49 is the empty mark, bit 48 the wrap mark, bits 47:32 the length and bits 31:0 the buffer pointer. While a buffer is offered, `buf_ptr`, `buf_len` and `buf_idx` give that slot's pointer, its length and its index.
- R7: On `frm_done`, the current slot is rewritten with the empty mark cleared, the length set to `frm_len`, and the wrap mark and pointer unchanged. Walking then continues at the next slot.
- R8: After a slot whose wrap mark is set, the next slot is slot 0. After the last slot (index DEPTH-1), the next slot is also slot 0, even when its wrap mark is clear.
- R9: Driving `mac_en` low returns the ring index to slot 0 and withdraws any buffer on offer.
- R10: If a doorbell write arrives in the same cycle as the hardware clear caused by a non-empty slot, the flag stays set and walking goes on.
- R11: A cycle with `frm_start` high while `buf_valid` is low adds 1 to `drop_cnt`. `drop_cnt` is 16 bits wide, starts at 0 after reset, and holds at 65535.
- R12: A cycle with `frm_start` high while `buf_valid` is high accepts the buffer. `buf_valid` then stays low until `frm_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mac_en | input | 1 | MAC receive enable |
| reg_wr | input | 1 | Doorbell write strobe |
| reg_wdata | input | 32 | Doorbell write data (value ignored) |
| reg_rdata | output | 32 | Doorbell readback, flag at bit 24 |
| dsc_wr | input | 1 | Software slot write strobe |
| dsc_wr_idx | input | 2 | Slot index for software write |
| dsc_wr_data | input | 50 | Slot contents to write |
| dsc_rd_idx | input | 2 | Slot index for software read |
| dsc_rd_data | output | 50 | Slot contents read |
| buf_valid | output | 1 | An empty buffer is on offer |
| buf_ptr | output | 32 | Pointer of the offered buffer |
| buf_len | output | 16 | Length field of the offered slot |
| buf_idx | output | 2 | Index of the current slot |
| frm_start | input | 1 | A frame begins |
| frm_done | input | 1 | The accepted frame has finished |
| frm_len | input | 16 | Received length reported with `frm_done` |
| drop_cnt | output | 16 | Saturating count of dropped frames |

## Verification
The assertions assume some rules about the inputs. `frm_done` comes only while a frame is in progress. `reg_wdata` carries no unknown bits during a write. Software does not rewrite the slot that hardware is writing back in the same cycle. The bench drives every input on the falling clock edge. It raises `frm_done` only after a buffer has been accepted, and it changes slots only while the walker is idle or waiting on another slot. The bench steps through every slot of a four-slot ring. It covers both ways of wrapping, the exact cycle of a doorbell write that coincides with a hardware clear, and a drop-counter run long enough to reach saturation.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int LEN_W = 16;
   localparam int PTR_W = 32;

   typedef struct packed {
      logic             empty;
      logic             wrap;
      logic [LEN_W-1:0] len;
      logic [PTR_W-1:0] ptr;
   } rx_desc_t;

   localparam int DESC_W = $bits(rx_desc_t);

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_READY = 2'd2,
      ST_BUSY  = 2'd3
   } walk_st_t;
endpackage

// File: rtl/rxr_doorbell.sv
module rxr_doorbell #(
   parameter int REG_W    = 32,
   parameter int FLAG_BIT = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mac_en,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   input  logic             hw_clr,
   output logic             active,
   output logic [REG_W-1:0] rdata
);
   if (FLAG_BIT < 0 || FLAG_BIT >= REG_W) begin : g_bad_bit
      $error("rxr_doorbell: FLAG_BIT outside register");
   end

   // enable low dominates, then a write, then the hardware clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       active <= 1'b0;
      else if (!mac_en) active <= 1'b0;
      else if (wr_en)   active <= 1'b1;
      else if (hw_clr)  active <= 1'b0;
   end

   for (genvar b = 0; b < REG_W; b++) begin : g_rd
      if (b == FLAG_BIT) begin : g_flag
         assign rdata[b] = active;
      end else begin : g_zero
         assign rdata[b] = 1'b0;
      end
   end

   p_wr_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mac_en) |=> active);
   p_wdata_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !$isunknown(wdata));
   p_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rdata) <= 1);
   p_hw_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_clr && !wr_en) |=> !active);
   p_en_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mac_en |=> !active);
   p_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_clr && wr_en && mac_en) |=> active);
endmodule

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem
   import rxr_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_we,
   input  logic [IDX_W-1:0] sw_idx,
   input  rx_desc_t         sw_data,
   input  logic             hw_we,
   input  logic [IDX_W-1:0] hw_idx,
   input  rx_desc_t         hw_data,
   input  logic [IDX_W-1:0] walk_idx,
   output rx_desc_t         walk_data,
   input  logic [IDX_W-1:0] peek_idx,
   output rx_desc_t         peek_data
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("rxr_desc_mem: DEPTH must be at least 2");
   end

   rx_desc_t slot [DEPTH];

   // hardware write-back wins over a software write to the same slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (hw_we && hw_idx == IDX_W'(i))      slot[i] <= hw_data;
            else if (sw_we && sw_idx == IDX_W'(i)) slot[i] <= sw_data;
         end
      end
   end

   assign walk_data = (int'(walk_idx) < DEPTH) ? slot[walk_idx] : '0;
   assign peek_data = (int'(peek_idx) < DEPTH) ? slot[peek_idx] : '0;

   p_hw_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hw_we |=> (slot[$past(hw_idx)] == $past(hw_data)));
endmodule

// File: rtl/rxr_ring_walk.sv
module rxr_ring_walk
   import rxr_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int DROP_W = 16,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam logic [DROP_W-1:0] DROP_MAX = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mac_en,
   input  logic              active,
   input  rx_desc_t          cur,
   input  logic              frm_start,
   input  logic              frm_done,
   input  logic [LEN_W-1:0]  frm_len,
   output logic [IDX_W-1:0]  idx,
   output logic              hw_clr,
   output logic              buf_valid,
   output logic [PTR_W-1:0]  buf_ptr,
   output logic [LEN_W-1:0]  buf_len,
   output logic              wb_we,
   output rx_desc_t          wb_data,
   output logic [DROP_W-1:0] drop_cnt
);
   if (DROP_W < 1) begin : g_bad_drop
      $error("rxr_ring_walk: DROP_W must be positive");
   end

   walk_st_t         st;
   rx_desc_t         held;
   logic [IDX_W-1:0] nxt_idx;
   logic             last_slot;

   assign last_slot = (idx == IDX_W'(DEPTH - 1));

   // a full binary ring rolls over by itself; otherwise compare with the end
   if ((1 << IDX_W) == DEPTH) begin : g_pow2
      assign nxt_idx = held.wrap ? '0 : idx + 1'b1;
   end else begin : g_odd
      assign nxt_idx = (held.wrap || last_slot) ? '0 : idx + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         idx  <= '0;
         held <= '0;
      end else if (!mac_en) begin
         st  <= ST_IDLE;
         idx <= '0;
      end else begin
         unique case (st)
            ST_IDLE:  if (active) st <= ST_FETCH;
            ST_FETCH: begin
               held <= cur;
               st   <= cur.empty ? ST_READY : ST_IDLE;
            end
            ST_READY: if (frm_start) st <= ST_BUSY;
            ST_BUSY: if (frm_done) begin
               idx <= nxt_idx;
               st  <= active ? ST_FETCH : ST_IDLE;
            end
            default:  st <= ST_IDLE;
         endcase
      end
   end

   assign hw_clr    = (st == ST_FETCH) && !cur.empty;
   assign buf_valid = (st == ST_READY);
   assign buf_ptr   = held.ptr;
   assign buf_len   = held.len;
   assign wb_we     = mac_en && (st == ST_BUSY) && frm_done;

   always_comb begin
      wb_data       = held;
      wb_data.empty = 1'b0;
      wb_data.len   = frm_len;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drop_cnt <= '0;
      else if (frm_start && !buf_valid && drop_cnt != DROP_MAX)
         drop_cnt <= drop_cnt + 1'b1;
   end

   p_idx_home_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !mac_en |=> (idx == '0 && !buf_valid));
   p_drop_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_start && !buf_valid && drop_cnt != DROP_MAX) |=> drop_cnt == $past(drop_cnt) + 1'b1);
   p_drop_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_cnt == DROP_MAX) |=> (drop_cnt == DROP_MAX));
   p_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_valid && frm_start && mac_en) |=> !buf_valid);
   p_wrap_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_we && (held.wrap || last_slot)) |=> idx == '0);
   p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      int'(idx) < DEPTH);
endmodule

// File: rtl/rx_ring_poller.sv
module rx_ring_poller
   import rxr_pkg::*;
#(
   parameter int DEPTH    = 4,
   parameter int REG_W    = 32,
   parameter int FLAG_BIT = 24,
   parameter int DROP_W   = 16,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mac_en,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              dsc_wr,
   input  logic [IDX_W-1:0]  dsc_wr_idx,
   input  logic [DESC_W-1:0] dsc_wr_data,
   input  logic [IDX_W-1:0]  dsc_rd_idx,
   output logic [DESC_W-1:0] dsc_rd_data,
   output logic              buf_valid,
   output logic [PTR_W-1:0]  buf_ptr,
   output logic [LEN_W-1:0]  buf_len,
   output logic [IDX_W-1:0]  buf_idx,
   input  logic              frm_start,
   input  logic              frm_done,
   input  logic [LEN_W-1:0]  frm_len,
   output logic [DROP_W-1:0] drop_cnt
);
   logic             active;
   logic             hw_clr;
   logic             wb_we;
   rx_desc_t         wb_data;
   rx_desc_t         cur;
   rx_desc_t         peek;
   logic [IDX_W-1:0] idx;

   rxr_doorbell #(.REG_W(REG_W), .FLAG_BIT(FLAG_BIT)) u_bell (
      .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .wr_en(reg_wr),
      .wdata(reg_wdata), .hw_clr(hw_clr), .active(active), .rdata(reg_rdata)
   );

   rxr_desc_mem #(.DEPTH(DEPTH)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .sw_we(dsc_wr), .sw_idx(dsc_wr_idx), .sw_data(rx_desc_t'(dsc_wr_data)),
      .hw_we(wb_we), .hw_idx(idx), .hw_data(wb_data),
      .walk_idx(idx), .walk_data(cur),
      .peek_idx(dsc_rd_idx), .peek_data(peek)
   );

   rxr_ring_walk #(.DEPTH(DEPTH), .DROP_W(DROP_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .active(active), .cur(cur),
      .frm_start(frm_start), .frm_done(frm_done), .frm_len(frm_len),
      .idx(idx), .hw_clr(hw_clr), .buf_valid(buf_valid), .buf_ptr(buf_ptr),
      .buf_len(buf_len), .wb_we(wb_we), .wb_data(wb_data), .drop_cnt(drop_cnt)
   );

   assign dsc_rd_data = peek;
   assign buf_idx     = idx;

   p_offer_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      buf_valid |-> active);
   p_no_offer_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !buf_valid && !reg_wr) |=> !buf_valid);
   p_ptr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_valid && $past(buf_valid)) |-> $stable(buf_ptr));
endmodule

// File: tb/tb_rx_ring_poller.sv
module tb_rx_ring_poller;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mac_en = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        dsc_wr = 1'b0;
   logic [1:0]  dsc_wr_idx = '0;
   logic [49:0] dsc_wr_data = '0;
   logic [1:0]  dsc_rd_idx = '0;
   logic [49:0] dsc_rd_data;
   logic        buf_valid;
   logic [31:0] buf_ptr;
   logic [15:0] buf_len;
   logic [1:0]  buf_idx;
   logic        frm_start = 1'b0;
   logic        frm_done = 1'b0;
   logic [15:0] frm_len = '0;
   logic [15:0] drop_cnt;

   int n_chk = 0;
   int n_bad = 0;
   localparam logic [31:0] FLAG = 32'h0100_0000;

   always #5 clk = ~clk;

   rx_ring_poller dut (
      .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dsc_wr(dsc_wr),
      .dsc_wr_idx(dsc_wr_idx), .dsc_wr_data(dsc_wr_data),
      .dsc_rd_idx(dsc_rd_idx), .dsc_rd_data(dsc_rd_data),
      .buf_valid(buf_valid), .buf_ptr(buf_ptr), .buf_len(buf_len),
      .buf_idx(buf_idx), .frm_start(frm_start), .frm_done(frm_done),
      .frm_len(frm_len), .drop_cnt(drop_cnt)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bell(input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic load(input int i, input bit e, input bit w, input logic [15:0] l,
                       input logic [31:0] p);
      @(negedge clk); dsc_wr = 1'b1; dsc_wr_idx = 2'(i); dsc_wr_data = {e, w, l, p};
      @(negedge clk); dsc_wr = 1'b0;
   endtask

   task automatic peek(input int i, output logic [49:0] d);
      dsc_rd_idx = 2'(i); #1; d = dsc_rd_data;
   endtask

   task automatic wait_buf(output bit got);
      got = 1'b0;
      for (int k = 0; k < 20; k++) begin
         if (buf_valid) begin got = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   task automatic run_frame(input int slot, input logic [15:0] l,
                            input bit w, input logic [31:0] p);
      logic [49:0] d;
      @(negedge clk); frm_start = 1'b1;
      @(negedge clk); frm_start = 1'b0;
      chk(!buf_valid, "R12 offer withdrawn", 64'(buf_valid), 0);
      tick(2);
      chk(!buf_valid, "R12 no offer while busy", 64'(buf_valid), 0);
      @(negedge clk); frm_done = 1'b1; frm_len = l;
      @(negedge clk); frm_done = 1'b0; frm_len = '0;
      peek(slot, d);
      chk(d == {1'b0, w, l, p}, "R7 write-back", 64'(d), 64'({1'b0, w, l, p}));
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [49:0] d;
      bit got;
      tick(3);
      chk(reg_rdata == 0, "R5 reset flag", 64'(reg_rdata), 0);
      chk(drop_cnt == 0, "R11 reset count", 64'(drop_cnt), 0);
      rst_n = 1'b1;
      tick(1);
      chk(!buf_valid, "R3 idle after reset", 64'(buf_valid), 0);

      load(0, 1, 0, 16'd1536, 32'hA000_0000);
      load(1, 1, 0, 16'd1536, 32'hA000_1000);
      load(2, 1, 1, 16'd1536, 32'hA000_2000);
      load(3, 1, 0, 16'd1536, 32'hA000_3000);
      peek(2, d);
      chk(d == {2'b11, 16'd1536, 32'hA000_2000}, "R6 slot layout", 64'(d),
          64'({2'b11, 16'd1536, 32'hA000_2000}));

      // doorbell while disabled
      bell(32'h0100_0000);
      chk(reg_rdata == 0, "R5 write ignored when disabled", 64'(reg_rdata), 0);
      mac_en = 1'b1;
      tick(5);
      chk(reg_rdata == 0, "R5 flag not latched", 64'(reg_rdata), 0);
      chk(!buf_valid, "R3 no offer without flag", 64'(buf_valid), 0);

      // R1 and R2: data zero still arms the flag
      bell(32'h0);
      chk(reg_rdata == FLAG, "R1 R2 flag at bit 24", 64'(reg_rdata), 64'(FLAG));
      wait_buf(got);
      chk(got && buf_idx == 0 && buf_ptr == 32'hA000_0000 && buf_len == 16'd1536,
          "R6 first offer", 64'({buf_idx, buf_ptr}), 64'({2'd0, 32'hA000_0000}));

      for (int s = 0; s < 3; s++) begin
         if (s > 0) begin
            wait_buf(got);
            chk(got && buf_idx == 2'(s) && buf_ptr == 32'hA000_0000 + 32'(s) * 32'h1000,
                "R7 advance to next slot", 64'(buf_idx), 64'(s));
         end
         run_frame(s, 16'(100 + s), s == 2, 32'hA000_0000 + 32'(s) * 32'h1000);
      end
      // slot 2 carries the wrap mark: back to slot 0, which is now full
      tick(4);
      chk(reg_rdata == 0, "R4 R8 stop at full slot 0", 64'(reg_rdata), 0);
      chk(!buf_valid && buf_idx == 0, "R8 wrap mark returns to 0", 64'(buf_idx), 0);
      tick(5);
      chk(!buf_valid, "R4 stays stopped", 64'(buf_valid), 0);

      // R11 drop with no buffer
      @(negedge clk); frm_start = 1'b1;
      @(negedge clk); frm_start = 1'b0;
      chk(drop_cnt == 1, "R11 drop counted", 64'(drop_cnt), 1);

      // R10 doorbell coinciding with hardware clear (slot 0 full)
      @(negedge clk); reg_wr = 1'b1; reg_wdata = 32'h5A5A_5A5A;
      @(negedge clk); reg_wr = 1'b0;
      @(negedge clk); reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
      chk(reg_rdata == FLAG, "R10 write beats clear", 64'(reg_rdata), 64'(FLAG));
      tick(4);
      chk(reg_rdata == 0, "R4 later clear", 64'(reg_rdata), 0);

      // refill slot 0, ring with all ones
      load(0, 1, 0, 16'd800, 32'hB000_0000);
      bell(32'hFFFF_FFFF);
      chk(reg_rdata == FLAG, "R1 R2 all-ones write", 64'(reg_rdata), 64'(FLAG));
      wait_buf(got);
      chk(got && buf_idx == 0 && buf_ptr == 32'hB000_0000 && buf_len == 16'd800,
          "R8 resumes at slot 0", 64'(buf_ptr), 64'(32'hB000_0000));
      load(1, 1, 0, 16'd900, 32'hB000_1000);
      run_frame(0, 16'd64, 0, 32'hB000_0000);
      wait_buf(got);
      chk(got && buf_idx == 1, "R7 on to slot 1", 64'(buf_idx), 1);

      // R9 enable drop while offering slot 1
      @(negedge clk); mac_en = 1'b0;
      tick(2);
      chk(!buf_valid && buf_idx == 0, "R9 index home", 64'(buf_idx), 0);
      chk(reg_rdata == 0, "R5 enable low clears", 64'(reg_rdata), 0);
      mac_en = 1'b1;

      // R8 last-slot wrap with no wrap marks
      for (int s = 0; s < 4; s++) load(s, 1, 0, 16'd256, 32'hC000_0000 + 32'(s) * 32'h100);
      bell(32'h1);
      for (int s = 0; s < 4; s++) begin
         wait_buf(got);
         chk(got && buf_idx == 2'(s) && buf_ptr == 32'hC000_0000 + 32'(s) * 32'h100,
             "R8 walk all slots", 64'(buf_idx), 64'(s));
         run_frame(s, 16'(60 + s), 0, 32'hC000_0000 + 32'(s) * 32'h100);
      end
      tick(4);
      chk(reg_rdata == 0 && buf_idx == 0, "R8 last slot wraps", 64'(buf_idx), 0);
      load(0, 1, 0, 16'd256, 32'hD000_0000);
      bell(32'h2);
      wait_buf(got);
      chk(got && buf_idx == 0 && buf_ptr == 32'hD000_0000, "R8 resume after last",
          64'(buf_ptr), 64'(32'hD000_0000));
      run_frame(0, 16'd10, 0, 32'hD000_0000);
      tick(4);

      // R11 saturation
      @(negedge clk); frm_start = 1'b1;
      tick(65540);
      @(negedge clk); frm_start = 1'b0;
      chk(drop_cnt == 16'hFFFF, "R11 saturates", 64'(drop_cnt), 64'hFFFF);
      tick(3);
      chk(drop_cnt == 16'hFFFF, "R11 holds", 64'(drop_cnt), 64'hFFFF);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule